// File: doc/BRIEF.md
# Bridge Read-Data Underflow Controller

This block paces the return of prefetched read data from a bridge's data buffer to the master that asked for it on the source bus. Words arrive in the buffer from the destination side. The block watches the buffer's fill level and decides when the first word may be offered. While data flows, it drives a target-ready strobe and a pop strobe. When the buffer runs dry before the destination side has flagged its last word, it chooses between two reactions.

A one-bit policy register picks between these reactions, and a new transaction copies its value when it begins. In the patient policy (register value 0), return begins once two words are buffered. An empty buffer then yields target wait states while prefetching goes on. After a bounded run of consecutive waits with no new data, the transfer is ended with a disconnect. In the strict policy (register value 1), return waits for a full cache line. An empty buffer then drops the prefetch request at once, disconnects the master, and tells the buffer to discard the entry. A completion flag from the destination side marks that the final word has been buffered. With this flag set, an empty buffer ends the transfer cleanly in either policy.

Top module: `rd_underflow_ctrl`

## Requirements
- R1: After reset the policy register reads as 0. A transaction started without any write to it behaves in the patient policy.
- R2: A transaction keeps the policy value that was held in the register when `txn_start` was seen in idle. A write to `cfg_wr` during the transaction changes only later transactions.
- R3: In the patient policy, `trdy` stays 0 while the buffer holds fewer than 2 words. `trdy` first rises on the cycle after the controller sees a level of at least 2.
- R4: In the strict policy, `trdy` stays 0 while the buffer holds fewer than `LINE_WORDS` words (default 8). `trdy` first rises on the cycle after the level reaches `LINE_WORDS`.
- R5: During return, `trdy` is 1 whenever the buffer is non-empty. `buf_pop` is 1 exactly when `trdy` and `src_ready` are both 1. `data_out` equals `buf_data`, so words reach the master in buffer order.
- R6: In the patient policy, with an empty buffer and `dst_done` low, up to `MAX_WAIT` consecutive cycles (default 7) show `trdy`=0, `stop`=0 and `pf_req`=1.
- R7: In the patient policy, if the buffer is still empty on the cycle after `MAX_WAIT` wait states, `stop` is 1 for one cycle with `discard`=0. After that cycle the controller is idle, with `trdy`, `stop` and `pf_req` all 0.
- R8: In the patient policy, a word that arrives during the wait window makes `trdy` 1 on the first cycle the level is non-zero, with no disconnect. Each transferred word restarts the count of consecutive waits.
- R9: In the strict policy, an empty buffer during return with `dst_done` low produces one cycle with `stop`=1, `discard`=1 and `pf_req`=0. The controller then returns to idle.
- R10: With `dst_done` high, an empty buffer during return produces `stop`=1 and `discard`=0 on the first empty cycle, with no wait states, in either policy. If the level is below the policy threshold but non-zero, return may begin once `dst_done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Write strobe for the policy register |
| cfg_wdata | input | 1 | Policy value: 0 patient, 1 strict |
| txn_start | input | 1 | A new read transaction begins (taken in idle) |
| buf_level | input | LVL_W | Number of words currently in the data buffer |
| buf_data | input | DW | Word at the head of the data buffer |
| dst_done | input | 1 | The last prefetched word has entered the buffer |
| src_ready | input | 1 | Source-bus master is ready to accept a word |
| trdy | output | 1 | Target ready toward the source bus |
| stop | output | 1 | Disconnect toward the source bus |
| discard | output | 1 | Flush the transaction entry and its buffered data |
| pf_req | output | 1 | Keep prefetching on the destination side |
| buf_pop | output | 1 | Remove the head word from the buffer |
| data_out | output | DW | Read data toward the source bus |

## Verification
The hardest case to reach is the restart of the wait count. The buffer must drain, stay empty for several cycles, then receive a single word late in the window. After that word transfers, a second full run of waits must follow. A disconnect only after this second run shows that the count was cleared. The bench models the buffer itself, so it can time one push to land on the fifth empty cycle and then starve the controller again. The policy latch is reached in a similar way. The register is rewritten while a strict-policy fill is halfway to a cache line, and the bench confirms that return still waits for the full line.

// File: rtl/rduf_pkg.sv
package rduf_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_FILL = 2'd1,
    ST_XFER = 2'd2
  } rduf_state_e;

  // Return may begin once the policy threshold is met, or early when the
  // destination has already delivered its final word.
  function automatic logic rduf_can_start(input logic line_mode,
                                          input int unsigned lvl,
                                          input logic done,
                                          input int unsigned line_words);
    int unsigned need;
    need = line_mode ? line_words : 32'd2;
    return (lvl >= need) || (done && (lvl != 0));
  endfunction

  // True once the consecutive-wait budget has been used up.
  function automatic logic rduf_budget_spent(input int unsigned cnt,
                                             input int unsigned max_wait);
    return cnt >= max_wait;
  endfunction

endpackage

// File: rtl/rduf_mode_reg.sv
module rduf_mode_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic cfg_wr,
  input  logic cfg_wdata,
  input  logic capture,
  output logic mode_q
);

  logic mode_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_r <= 1'b0;
    else if (cfg_wr) mode_r <= cfg_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= 1'b0;
    else if (capture) mode_q <= mode_r;
  end

  // R1: policy register comes out of reset as patient
  assert_mode_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!mode_r && !mode_q));

endmodule

// File: rtl/rduf_wait_ctr.sv
module rduf_wait_ctr #(
  parameter int MAX_WAIT = 7,
  localparam int WCNT_W = $clog2(MAX_WAIT + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic inc,
  output logic spent
);

  logic [WCNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else if (clr) cnt_q <= '0;
    else if (inc && (cnt_q != WCNT_W'(MAX_WAIT))) cnt_q <= cnt_q + 1'b1;
  end

  assign spent = rduf_pkg::rduf_budget_spent(32'(cnt_q), MAX_WAIT);

  // R6: the budget only becomes spent after a wait state was requested
  assert_spent_needs_wait_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spent) |-> $past(inc));

  // R8: a clear empties the budget on the next cycle
  assert_clear_resets_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !spent);

endmodule

// File: rtl/rduf_seq.sv
module rduf_seq
  import rduf_pkg::*;
#(
  parameter int LVL_W = 5,
  parameter int LINE_WORDS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             txn_start,
  input  logic             mode_q,
  input  logic [LVL_W-1:0] buf_level,
  input  logic             src_ready,
  input  logic             dst_done,
  input  logic             wait_spent,
  output logic             trdy,
  output logic             stop,
  output logic             discard,
  output logic             pf_req,
  output logic             buf_pop,
  output logic             wait_clr,
  output logic             wait_inc,
  output logic             idle
);

  rduf_state_e state_q, state_d;
  logic        empty;
  logic        start_ok;

  assign empty    = (buf_level == '0);
  assign start_ok = rduf_can_start(mode_q, 32'(buf_level), dst_done, LINE_WORDS);
  assign idle     = (state_q == ST_IDLE);

  always_comb begin
    state_d  = state_q;
    trdy     = 1'b0;
    stop     = 1'b0;
    discard  = 1'b0;
    pf_req   = 1'b0;
    buf_pop  = 1'b0;
    wait_clr = 1'b0;
    wait_inc = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (txn_start) begin
          wait_clr = 1'b1;
          state_d  = ST_FILL;
        end
      end
      ST_FILL: begin
        pf_req = !dst_done;
        if (start_ok) begin
          state_d = ST_XFER;
        end else if (dst_done && empty) begin
          stop    = 1'b1;
          state_d = ST_IDLE;
        end
      end
      ST_XFER: begin
        if (!empty) begin
          trdy     = 1'b1;
          buf_pop  = src_ready;
          wait_clr = src_ready;
          pf_req   = !dst_done;
        end else if (dst_done) begin
          stop    = 1'b1;
          state_d = ST_IDLE;
        end else if (mode_q) begin
          stop    = 1'b1;
          discard = 1'b1;
          state_d = ST_IDLE;
        end else if (wait_spent) begin
          stop    = 1'b1;
          state_d = ST_IDLE;
        end else begin
          pf_req   = 1'b1;
          wait_inc = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else state_q <= state_d;
  end

  // R5: never pop an empty buffer
  assert_pop_nonempty_R5: assert property (@(posedge clk) disable iff (!rst_n)
    buf_pop |-> !empty);

  // R7: after a disconnect the controller is idle
  assert_stop_then_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> (idle && !trdy));

  // R7: a patient-policy underflow disconnect only after the wait budget is spent
  assert_stop_after_budget_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (stop && !discard && !dst_done && !mode_q) |-> wait_spent);

  // R9: discard only in the strict policy, together with a disconnect and no prefetch
  assert_discard_strict_R9: assert property (@(posedge clk) disable iff (!rst_n)
    discard |-> (mode_q && stop && !pf_req));

  // R3: no ready in the patient policy until two words were seen in fill
  assert_patient_threshold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_FILL && !mode_q && !dst_done && buf_level < LVL_W'(2)) |=> !trdy);

endmodule

// File: rtl/rd_underflow_ctrl.sv
module rd_underflow_ctrl #(
  parameter int DW = 32,
  parameter int DEPTH = 16,
  parameter int LINE_WORDS = 8,
  parameter int MAX_WAIT = 7,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic             cfg_wdata,
  input  logic             txn_start,
  input  logic [LVL_W-1:0] buf_level,
  input  logic [DW-1:0]    buf_data,
  input  logic             dst_done,
  input  logic             src_ready,
  output logic             trdy,
  output logic             stop,
  output logic             discard,
  output logic             pf_req,
  output logic             buf_pop,
  output logic [DW-1:0]    data_out
);

  logic mode_q;
  logic idle_w;
  logic start_evt;
  logic wait_clr;
  logic wait_inc;
  logic wait_spent;

  assign start_evt = idle_w && txn_start;
  assign data_out  = buf_data;

  rduf_mode_reg u_mode (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_wr    (cfg_wr),
    .cfg_wdata (cfg_wdata),
    .capture   (start_evt),
    .mode_q    (mode_q)
  );

  rduf_wait_ctr #(.MAX_WAIT(MAX_WAIT)) u_wait (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (wait_clr),
    .inc   (wait_inc),
    .spent (wait_spent)
  );

  rduf_seq #(.LVL_W(LVL_W), .LINE_WORDS(LINE_WORDS)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .txn_start  (txn_start),
    .mode_q     (mode_q),
    .buf_level  (buf_level),
    .src_ready  (src_ready),
    .dst_done   (dst_done),
    .wait_spent (wait_spent),
    .trdy       (trdy),
    .stop       (stop),
    .discard    (discard),
    .pf_req     (pf_req),
    .buf_pop    (buf_pop),
    .wait_clr   (wait_clr),
    .wait_inc   (wait_inc),
    .idle       (idle_w)
  );

  // R2: the latched policy stays fixed for the whole transaction
  assert_policy_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!idle_w && !$past(idle_w)) |-> $stable(mode_q));

  // R5: ready and disconnect are never offered together
  assert_ready_xor_stop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(trdy && stop));

endmodule

// File: tb/sim_rd_underflow_ctrl.sv
module sim_rd_underflow_ctrl;

  localparam int DW = 32;
  localparam int LVL_W = 5;
  localparam int LINE = 8;
  localparam int MAXW = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_wr = 1'b0, cfg_wdata = 1'b0, txn_start = 1'b0;
  logic push = 1'b0, src_ready = 1'b0, dst_done = 1'b0;
  logic [LVL_W-1:0] buf_level;
  logic [DW-1:0] buf_data;
  logic trdy, stop, discard, pf_req, buf_pop;
  logic [DW-1:0] data_out;

  int rd_ptr = 0, wr_ptr = 0, pushed = 0;
  int checks = 0, failures = 0;
  bit finished = 0;
  bit cfg_req = 0, cfg_val = 0;
  logic [DW-1:0] exp_q [$];

  always #2 clk = ~clk;

  rd_underflow_ctrl #(.DW(DW), .DEPTH(16), .LINE_WORDS(LINE), .MAX_WAIT(MAXW)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .txn_start(txn_start), .buf_level(buf_level), .buf_data(buf_data),
    .dst_done(dst_done), .src_ready(src_ready), .trdy(trdy), .stop(stop),
    .discard(discard), .pf_req(pf_req), .buf_pop(buf_pop), .data_out(data_out));

  // Bench-side buffer model: words are numbered by position.
  assign buf_level = LVL_W'(wr_ptr - rd_ptr);
  assign buf_data  = 32'hA000_0000 + 32'(rd_ptr);

  always @(posedge clk) begin
    if (discard) rd_ptr <= wr_ptr + (push ? 1 : 0);
    else if (buf_pop) rd_ptr <= rd_ptr + 1;
    if (push) wr_ptr <= wr_ptr + 1;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Monitor: every popped word must match the oldest expected word.
  always begin
    @(negedge clk);
    #1;
    if (rst_n && buf_pop) begin
      if (exp_q.size() == 0) chk("R5 unexpected pop", 32'd1, 32'd0);
      else chk("R5 data order", data_out, exp_q.pop_front());
    end
    if (rst_n && discard) exp_q.delete();
  end

  // Driver: one cycle of stimulus; pushed words are expected by the scoreboard.
  task automatic tick(input logic st, input logic p, input logic r, input logic d);
    @(negedge clk);
    txn_start = st; push = p; src_ready = r; dst_done = d;
    cfg_wr = cfg_req; cfg_wdata = cfg_val; cfg_req = 0;
    if (p) begin
      exp_q.push_back(32'hA000_0000 + 32'(pushed));
      pushed++;
    end
    #1;
  endtask

  initial begin
    #800000;
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // reset state
    repeat (3) tick(0, 0, 0, 0);
    chk("R1 reset trdy", 32'(trdy), 0);
    chk("R1 reset stop", 32'(stop), 0);
    chk("R1 reset pf_req", 32'(pf_req), 0);
    rst_n = 1'b1;
    tick(0, 0, 0, 0);

    // Patient policy from reset (R1, R3, R5, R6, R7)
    tick(1, 0, 0, 0);
    chk("R7 idle pf_req", 32'(pf_req), 0);
    tick(0, 1, 0, 0);
    chk("R3 fill lvl0 trdy", 32'(trdy), 0);
    chk("R6 fill pf_req", 32'(pf_req), 1);
    tick(0, 1, 0, 0);
    chk("R3 fill lvl1 trdy", 32'(trdy), 0);
    tick(0, 0, 1, 0);
    chk("R1 lvl2 seen, trdy not yet", 32'(trdy), 0);
    tick(0, 0, 0, 0);
    chk("R3 trdy after two words", 32'(trdy), 1);
    chk("R5 no pop without src_ready", 32'(buf_pop), 0);
    tick(0, 0, 1, 0);
    chk("R5 pop with src_ready", 32'(buf_pop), 1);
    tick(0, 0, 1, 0);
    chk("R5 second pop", 32'(buf_pop), 1);
    for (int i = 0; i < MAXW; i++) begin
      tick(0, 0, 1, 0);
      chk("R6 wait trdy", 32'(trdy), 0);
      chk("R6 wait stop", 32'(stop), 0);
      chk("R6 wait pf_req", 32'(pf_req), 1);
    end
    tick(0, 0, 1, 0);
    chk("R7 stop after budget", 32'(stop), 1);
    chk("R7 no discard", 32'(discard), 0);
    tick(0, 0, 1, 0);
    chk("R7 idle stop", 32'(stop), 0);
    chk("R7 idle pf_req", 32'(pf_req), 0);
    chk("R7 idle trdy", 32'(trdy), 0);

    // Late arrival restarts the wait budget (R8)
    tick(1, 0, 0, 0);
    tick(0, 1, 0, 0);
    tick(0, 1, 0, 0);
    tick(0, 0, 1, 0);
    tick(0, 0, 1, 0);
    tick(0, 0, 1, 0);
    for (int i = 0; i < 4; i++) tick(0, 0, 1, 0);
    tick(0, 1, 1, 0);
    chk("R8 fifth wait no stop", 32'(stop), 0);
    tick(0, 0, 1, 0);
    chk("R8 resume trdy", 32'(trdy), 1);
    chk("R8 resume no stop", 32'(stop), 0);
    for (int i = 0; i < MAXW; i++) begin
      tick(0, 0, 1, 0);
      chk("R8 fresh budget no stop", 32'(stop), 0);
    end
    tick(0, 0, 1, 0);
    chk("R8 stop after fresh budget", 32'(stop), 1);
    tick(0, 0, 0, 0);

    // Strict policy; rewrite during fill must not take effect (R4, R2, R9)
    cfg_req = 1; cfg_val = 1;
    tick(0, 0, 0, 0);
    tick(1, 0, 0, 0);
    for (int i = 0; i < LINE; i++) begin
      if (i == 3) begin cfg_req = 1; cfg_val = 0; end
      tick(0, 1, 0, 0);
      chk(i >= 2 ? "R2 latched strict trdy" : "R4 fill trdy", 32'(trdy), 0);
    end
    tick(0, 0, 1, 0);
    chk("R4 line seen, trdy not yet", 32'(trdy), 0);
    for (int i = 0; i < LINE; i++) begin
      tick(0, 0, 1, 0);
      chk("R4 trdy during line", 32'(trdy), 1);
    end
    tick(0, 0, 1, 0);
    chk("R9 stop", 32'(stop), 1);
    chk("R9 discard", 32'(discard), 1);
    chk("R9 pf_req dropped", 32'(pf_req), 0);
    tick(0, 0, 1, 0);
    chk("R9 idle trdy", 32'(trdy), 0);
    chk("R9 idle stop", 32'(stop), 0);

    // Register now 0: patient threshold again, clean completion (R2, R10)
    tick(1, 0, 0, 0);
    tick(0, 1, 0, 0);
    tick(0, 1, 0, 0);
    tick(0, 0, 1, 1);
    tick(0, 0, 1, 1);
    chk("R2 new txn uses rewritten policy", 32'(trdy), 1);
    tick(0, 0, 1, 1);
    chk("R10 last word", 32'(trdy), 1);
    tick(0, 0, 1, 1);
    chk("R10 stop on first empty", 32'(stop), 1);
    chk("R10 no discard", 32'(discard), 0);
    tick(0, 0, 0, 0);

    // Strict policy short completion below line threshold (R10)
    cfg_req = 1; cfg_val = 1;
    tick(0, 0, 0, 0);
    tick(1, 0, 0, 0);
    for (int i = 0; i < 3; i++) tick(0, 1, 0, 0);
    tick(0, 0, 1, 1);
    for (int i = 0; i < 3; i++) begin
      tick(0, 0, 1, 1);
      chk("R10 strict short return", 32'(trdy), 1);
    end
    tick(0, 0, 1, 1);
    chk("R10 strict clean stop", 32'(stop), 1);
    chk("R10 strict no discard", 32'(discard), 0);
    tick(0, 0, 0, 0);
    tick(0, 0, 0, 0);
    chk("R5 scoreboard drained", 32'(exp_q.size()), 0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule